// File: doc/BRIEF.md
# Half-Bridge Gate Control Logic

This block is the synchronous control core for one leg of a half bridge. It takes active-high high-side and low-side switch commands, an active-low shutdown line, an overcurrent flag, and undervoltage flags for the low-side supply and the bootstrap supply. All of these arrive already digitised. From them it produces the two gate-enable outputs and the enable for an open-drain pull-down that flags a fault on the shared shutdown line.

The block decodes the two commands under a cross-conduction interlock. It makes sure one gate has been off for a programmable number of clock cycles before the opposite gate may turn on. An overcurrent flag kills both gates at once through a combinational path that does not wait for the synchronizers. The fault is then latched, and the pull-down stays asserted until the shutdown line is seen low. After that the block waits for the shutdown line to return high before normal switching resumes.

Every input passes through a two-stage synchronizer before it reaches the decode logic. The reset is synchronous and active high.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While the synchronized shutdown input `sd_n` is 0, both `hi_gate` and `lo_gate` are 0, whatever the commands are.
- R2: When `hi_cmd` and `lo_cmd` are both 1, both gates are 0. `hi_gate` and `lo_gate` are never 1 in the same cycle.
- R3: With `sd_n` = 1 and no undervoltage, the gates follow the commands: `hi_cmd` = 1 alone gives `hi_gate` = 1, `lo_cmd` = 1 alone gives `lo_gate` = 1, and both commands 0 gives both gates 0.
- R4: Before either gate turns on, both gates have been 0 for exactly `DEAD_CYCLES` consecutive clock cycles (default 23 cycles, about 184 ns at 125 MHz). This holds whenever the other gate was on.
- R5: When `oc_flag` is 1, both gate outputs are 0 in the same cycle, through a combinational path. The gate registers are cleared at the next clock edge.
- R6: An overcurrent event seen by the synchronizer asserts `od_pull` within three clock edges. `od_pull` then stays 1 for as long as the synchronized `sd_n` is 1, even after `oc_flag` returns to 0.
- R7: Once the synchronized `sd_n` is 0 during a fault, `od_pull` is released. The gates stay 0 until `sd_n` is 1 again. After that the commands are obeyed again.
- R8: `uv_vcc` = 1 forces both gates to 0. `uv_boot` = 1 forces only `hi_gate` to 0; the low-side command still drives `lo_gate`.
- R9: Reset forces both gates and `od_pull` to 0, clears the fault hold, and loads the dead-time count as if both gates had just turned off. With `hi_cmd` held at 1, the first `hi_gate` rise comes after `DEAD_CYCLES` cycles counted from the reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_cmd | input | 1 | High-side switch command, active high |
| lo_cmd | input | 1 | Low-side switch command, active high |
| sd_n | input | 1 | Shutdown line, active low |
| oc_flag | input | 1 | Overcurrent comparator flag, active high |
| uv_vcc | input | 1 | Low-side supply undervoltage flag |
| uv_boot | input | 1 | Bootstrap supply undervoltage flag |
| hi_gate | output | 1 | High-side gate enable |
| lo_gate | output | 1 | Low-side gate enable |
| od_pull | output | 1 | Open-drain pull-down enable for the shutdown line |

## Verification
The decode is tried against every command pair with the shutdown line high and low. This tells interlock apart from a plain shutdown, and a single-side command apart from idle. Each undervoltage flag is then applied under both single-side commands, which shows that the bootstrap flag blocks only the high side while the supply flag blocks both. Turn-on timing is measured as a count of cycles in which both gates are low: for low-to-high and high-to-low transfers, and from reset release. A full fault sequence shows the immediate gate kill, the held pull-down after the flag clears, the release on a low shutdown line, and the resumption of switching.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Synchronized view of all asynchronous inputs
    typedef struct packed {
        logic hi;
        logic lo;
        logic sd_n;
        logic oc;
        logic uv_vcc;
        logic uv_boot;
    } hb_in_t;

    localparam int HB_IN_W = $bits(hb_in_t);

    // Fault hold state
    typedef enum logic [1:0] {
        FLT_RUN   = 2'd0,
        FLT_TRIP  = 2'd1,
        FLT_REARM = 2'd2
    } flt_state_t;

    // Requested gate pair from the command decode
    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    function automatic gate_pair_t decode_cmd(input logic hi, input logic lo,
                                              input logic en_all, input logic en_hi);
        gate_pair_t g;
        g.hi = hi & ~lo & en_all & en_hi;
        g.lo = lo & ~hi & en_all;
        return g;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hb_fault.sv
module hb_fault
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic s_oc,
    input  logic s_sd_n,
    output logic run_ok,
    output logic od_pull
);
    flt_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            FLT_RUN:   if (s_oc) state_d = FLT_TRIP;
            FLT_TRIP:  if (!s_sd_n) state_d = FLT_REARM;
            FLT_REARM: begin
                if (s_oc)        state_d = FLT_TRIP;
                else if (s_sd_n) state_d = FLT_RUN;
            end
            default:   state_d = FLT_TRIP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FLT_RUN;
        else     state_q <= state_d;
    end

    assign run_ok  = (state_q == FLT_RUN);
    assign od_pull = (state_q == FLT_TRIP);

    // R6: a seen fault with the line high leaves the pull-down active
    assert_trip_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (s_oc && s_sd_n) |=> od_pull);
    // R6: pull-down is not dropped while the line still reads high
    assert_pull_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (od_pull && s_sd_n) |=> od_pull);
    // R7: a low line releases the pull-down
    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        (od_pull && !s_sd_n) |=> !od_pull);
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime #(
    parameter int DEAD_CYCLES = 23
) (
    input  logic clk,
    input  logic rst,
    input  logic req_hi,
    input  logic req_lo,
    input  logic kill,
    output logic hi_q,
    output logic lo_q
);
    localparam int LIMIT = DEAD_CYCLES - 1;
    localparam int CW    = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] off_cnt;
    logic          cnt_done;

    assign cnt_done = (off_cnt == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            off_cnt <= '0;
            hi_q    <= 1'b0;
            lo_q    <= 1'b0;
        end else begin
            if (hi_q || lo_q)  off_cnt <= '0;
            else if (!cnt_done) off_cnt <= off_cnt + 1'b1;
            hi_q <= ~kill & req_hi & (hi_q | (~lo_q & cnt_done));
            lo_q <= ~kill & req_lo & (lo_q | (~hi_q & cnt_done));
        end
    end

    // R4: a gate only rises after the other has been low for two cycles at least
    assert_dead_hi_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_q) |-> (!$past(lo_q) && !$past(lo_q, 2)));
    assert_dead_lo_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_q) |-> (!$past(hi_q) && !$past(hi_q, 2)));
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_pkg::*;
#(
    parameter int DEAD_CYCLES = 23,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic sd_n,
    input  logic oc_flag,
    input  logic uv_vcc,
    input  logic uv_boot,
    output logic hi_gate,
    output logic lo_gate,
    output logic od_pull
);
    hb_in_t     raw_in, s_in;
    gate_pair_t req;
    logic       run_ok, en_all, en_hi;
    logic       hi_q, lo_q;

    always_comb begin
        raw_in.hi      = hi_cmd;
        raw_in.lo      = lo_cmd;
        raw_in.sd_n    = sd_n;
        raw_in.oc      = oc_flag;
        raw_in.uv_vcc  = uv_vcc;
        raw_in.uv_boot = uv_boot;
    end

    hb_sync #(.W(HB_IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (s_in)
    );

    hb_fault u_fault (
        .clk    (clk),
        .rst    (rst),
        .s_oc   (s_in.oc),
        .s_sd_n (s_in.sd_n),
        .run_ok (run_ok),
        .od_pull(od_pull)
    );

    assign en_all = run_ok & s_in.sd_n & ~s_in.uv_vcc & ~s_in.oc;
    assign en_hi  = ~s_in.uv_boot;
    assign req    = decode_cmd(s_in.hi, s_in.lo, en_all, en_hi);

    hb_deadtime #(.DEAD_CYCLES(DEAD_CYCLES)) u_dead (
        .clk    (clk),
        .rst    (rst),
        .req_hi (req.hi),
        .req_lo (req.lo),
        .kill   (oc_flag),
        .hi_q   (hi_q),
        .lo_q   (lo_q)
    );

    // Fast fault path: raw flag masks the registered gates directly
    assign hi_gate = hi_q & ~oc_flag;
    assign lo_gate = lo_q & ~oc_flag;

    // R2: no cross conduction at the outputs
    assert_interlock_R2: assert property (@(posedge clk) disable iff (rst)
        !(hi_gate && lo_gate));
    // R1: synchronized shutdown clears both gate registers
    assert_sd_off_R1: assert property (@(posedge clk) disable iff (rst)
        !s_in.sd_n |=> (!hi_q && !lo_q));
    // R5: raw fault clears the gate registers at the next edge
    assert_fast_off_R5: assert property (@(posedge clk) disable iff (rst)
        oc_flag |=> (!hi_q && !lo_q));
    // R8: bootstrap undervoltage blocks the high side
    assert_uv_boot_R8: assert property (@(posedge clk) disable iff (rst)
        s_in.uv_boot |=> !hi_q);
    // R8: supply undervoltage blocks both sides
    assert_uv_vcc_R8: assert property (@(posedge clk) disable iff (rst)
        s_in.uv_vcc |=> (!hi_q && !lo_q));
endmodule

// File: tb/sim_hb_gate_ctrl.sv
module sim_hb_gate_ctrl;
    localparam int DEAD = 23;
    localparam int NVEC = 11;
    localparam int SETTLE = DEAD + 12;

    // {req_no[3:0], sd_n, hi, lo, uv_vcc, uv_boot, exp_hi, exp_lo}
    localparam logic [10:0] VEC [NVEC] = '{
        {4'd3, 7'b1_0_0_0_0_0_0},   // R3 idle
        {4'd3, 7'b1_1_0_0_0_1_0},   // R3 high only
        {4'd3, 7'b1_0_1_0_0_0_1},   // R3 low only
        {4'd2, 7'b1_1_1_0_0_0_0},   // R2 interlock
        {4'd1, 7'b0_1_0_0_0_0_0},   // R1 shutdown, high cmd
        {4'd1, 7'b0_0_1_0_0_0_0},   // R1 shutdown, low cmd
        {4'd8, 7'b1_1_0_1_0_0_0},   // R8 supply uv, high cmd
        {4'd8, 7'b1_0_1_1_0_0_0},   // R8 supply uv, low cmd
        {4'd8, 7'b1_1_0_0_1_0_0},   // R8 boot uv, high cmd
        {4'd8, 7'b1_0_1_0_1_0_1},   // R8 boot uv, low cmd
        {4'd3, 7'b1_1_0_0_0_1_0}    // R3 high only again
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hi_cmd = 1'b0, lo_cmd = 1'b0, sd_n = 1'b1, oc_flag = 1'b0;
    logic uv_vcc = 1'b0, uv_boot = 1'b0;
    logic hi_gate, lo_gate, od_pull;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    hb_gate_ctrl #(.DEAD_CYCLES(DEAD)) u0 (
        .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .sd_n(sd_n),
        .oc_flag(oc_flag), .uv_vcc(uv_vcc), .uv_boot(uv_boot),
        .hi_gate(hi_gate), .lo_gate(lo_gate), .od_pull(od_pull)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        int n;
        // R9: reset state with high command held; count low cycles after release
        hi_cmd = 1'b1;
        wait_cyc(5);
        check(!hi_gate && !lo_gate && !od_pull, "R9 reset outputs",
              {hi_gate, lo_gate, od_pull}, 0);
        rst = 1'b0;
        n = 0;
        while (!hi_gate && n < 200) begin
            n++;
            @(negedge clk);
        end
        check(n == DEAD, "R9 first turn-on delay", n, DEAD);

        // Truth table walk
        for (int v = 0; v < NVEC; v++) begin
            sd_n    = VEC[v][6];
            hi_cmd  = VEC[v][5];
            lo_cmd  = VEC[v][4];
            uv_vcc  = VEC[v][3];
            uv_boot = VEC[v][2];
            wait_cyc(SETTLE);
            check({hi_gate, lo_gate} == VEC[v][1:0],
                  $sformatf("R%0d vector %0d", VEC[v][10:7], v),
                  {hi_gate, lo_gate}, VEC[v][1:0]);
        end

        // R4: high to low transfer, count both-low cycles
        hi_cmd = 1'b0; lo_cmd = 1'b1;
        n = 0;
        while (hi_gate && n < 20) begin n++; @(negedge clk); end
        n = 0;
        while (!hi_gate && !lo_gate && n < 200) begin n++; @(negedge clk); end
        check(n == DEAD && lo_gate, "R4 gap high to low", n, DEAD);

        // R4: low to high transfer
        wait_cyc(5);
        hi_cmd = 1'b1; lo_cmd = 1'b0;
        n = 0;
        while (lo_gate && n < 20) begin n++; @(negedge clk); end
        n = 0;
        while (!hi_gate && !lo_gate && n < 200) begin n++; @(negedge clk); end
        check(n == DEAD && hi_gate, "R4 gap low to high", n, DEAD);

        // R5: overcurrent kills the gate in the same cycle
        wait_cyc(5);
        oc_flag = 1'b1;
        #1;
        check(!hi_gate && !lo_gate, "R5 immediate gate off", {hi_gate, lo_gate}, 0);

        // R6: pull-down asserted and held while sd_n high
        wait_cyc(4);
        check(od_pull == 1'b1, "R6 pull-down asserted", od_pull, 1);
        oc_flag = 1'b0;
        wait_cyc(20);
        check(od_pull == 1'b1, "R6 pull-down held after flag clears", od_pull, 1);
        check(!hi_gate && !lo_gate, "R6 gates off while held", {hi_gate, lo_gate}, 0);

        // R7: low line releases the pull-down, gates stay off
        sd_n = 1'b0;
        wait_cyc(4);
        check(od_pull == 1'b0, "R7 pull-down released", od_pull, 0);
        wait_cyc(SETTLE);
        check(!hi_gate && !lo_gate, "R7 gates off while line low", {hi_gate, lo_gate}, 0);
        sd_n = 1'b1;
        wait_cyc(SETTLE);
        check(hi_gate && !lo_gate && !od_pull, "R7 resume after line high",
              {hi_gate, lo_gate, od_pull}, 4);

        // R9: reset in the middle of operation
        rst = 1'b1;
        wait_cyc(1);
        check(!hi_gate && !lo_gate && !od_pull, "R9 reset while running",
              {hi_gate, lo_gate, od_pull}, 0);
        rst = 1'b0;
        wait_cyc(SETTLE);
        check(hi_gate == 1'b1, "R9 operation after reset", hi_gate, 1);

        finish_run();
    end
endmodule